// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a shift register of the directions of the most recent resolved branches. That global history is XOR-ed with a field of the branch address to pick one entry of a table of two-bit saturating counters. The upper bit of the chosen counter is the guess. The block looks up any address presented at the lookup port in the same cycle. It returns the guess and also the table index it used.

When the branch resolves, the pipeline sends that index back on the training port along with the real outcome. The counter that made the guess is therefore trained, even if younger branches have since moved the history on. The same training event shifts the outcome into the history. After a misprediction the pipeline can overwrite the history with a saved copy. The restore input serves that purpose and takes priority over the shift in that cycle.

Top module: `gshare_predictor`

## Requirements
- R1: While reset is high, and on the first cycle after it, the history is all zeros and every counter holds weakly taken (10), so every address predicts taken.
- R2: The lookup index equals history XOR `pred_pc[PC_LSB +: HIST_W]`. It is driven on `pred_idx` in the same cycle as the address.
- R3: `pred_taken` is the upper bit of the selected counter, so counter values 11 and 10 predict taken and 01 and 00 predict not taken.
- R4: A taken outcome raises the counter by one and saturates at 11. A not-taken outcome lowers it by one and saturates at 00.
- R5: From a strong state (11 or 00), one opposite outcome leaves the prediction unchanged, and a second consecutive opposite outcome flips it.
- R6: Training takes effect on the clock edge at which `upd_valid` is high. It changes only the counter at the supplied `upd_idx`, whatever the current history is.
- R7: Each training event shifts `upd_taken` into history bit 0 and drops the oldest bit. History 1110 followed by a taken outcome becomes 1101 (bit 3 first).
- R8: When `hist_restore` is high, the history loads `hist_restore_val` on that edge in place of the shift. A training event in the same cycle still updates its counter.
- R9: On an edge with neither `upd_valid` nor `hist_restore` high, the history and all counters stay unchanged.
- R10: For a branch that strictly alternates taken, not-taken and always maps to one counter, starting from the reset state, exactly half of the predictions are correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_pc | input | PC_W | Address of the branch to look up |
| pred_taken | output | 1 | Guess: 1 = taken |
| pred_idx | output | HIST_W | Table index used for this lookup |
| upd_valid | input | 1 | Training event this cycle |
| upd_idx | input | HIST_W | Index returned at lookup time for the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch |
| hist_restore | input | 1 | Load the history from `hist_restore_val` |
| hist_restore_val | input | HIST_W | History value to load |

## Verification
The bench builds the block with HIST_W = 4, PC_W = 16 and PC_LSB = 2, which gives a 16-entry table. At that size a short run can sweep every entry after each scenario. It can also fill the whole history with a known pattern in four training events, and can choose an address that steers any history onto a chosen counter. With those settings, saturation at both ends, hysteresis, the same-cycle mix of restore and training, and the alternating-branch accuracy all fall within a few hundred cycles. A reference model in the bench tracks all of these.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_e;

    localparam ctr_e CTR_RESET = CTR_WEAK_T;

    // Saturating step of one counter toward the observed outcome.
    function automatic ctr_e ctr_train(input ctr_e cur, input logic taken);
        ctr_e nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_STRONG_T) nxt = ctr_e'(cur + 2'b01);
        end else begin
            if (cur != CTR_STRONG_NT) nxt = ctr_e'(cur - 2'b01);
        end
        return nxt;
    endfunction

    function automatic logic ctr_says_taken(input ctr_e cur);
        return cur[1];
    endfunction

    typedef enum logic [1:0] {
        HIST_HOLD    = 2'b00,
        HIST_SHIFT   = 2'b01,
        HIST_RESTORE = 2'b10
    } hist_op_e;

endpackage

// File: rtl/gshare_history.sv
module gshare_history
    import gshare_pkg::*;
#(
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              shift_bit,
    input  logic              restore_en,
    input  logic [HIST_W-1:0] restore_val,
    output logic [HIST_W-1:0] hist
);
    logic [HIST_W-1:0] hist_q;
    hist_op_e          op;

    always_comb begin
        if (restore_en)    op = HIST_RESTORE;
        else if (shift_en) op = HIST_SHIFT;
        else               op = HIST_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else begin
            unique case (op)
                HIST_RESTORE: hist_q <= restore_val;
                HIST_SHIFT:   hist_q <= {hist_q[HIST_W-2:0], shift_bit};
                default:      hist_q <= hist_q;
            endcase
        end
    end

    assign hist = hist_q;
endmodule

// File: rtl/gshare_hash.sv
module gshare_hash #(
    parameter int HIST_W = 10,
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [HIST_W-1:0] idx
);
    logic unused_pc_bits;

    assign idx            = hist ^ pc[PC_LSB +: HIST_W];
    assign unused_pc_bits = ^pc;
endmodule

// File: rtl/gshare_pht.sv
module gshare_pht
    import gshare_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_e             rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int DEPTH = 1 << IDX_W;

    ctr_e table_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) table_q[i] <= CTR_RESET;
        end else if (wr_en) begin
            table_q[wr_idx] <= ctr_train(table_q[wr_idx], wr_taken);
        end
    end

    assign rd_ctr = table_q[rd_idx];
endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
    import gshare_pkg::*;
#(
    parameter int HIST_W = 10,
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PC_W-1:0]   pred_pc,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_idx,
    input  logic              upd_valid,
    input  logic [HIST_W-1:0] upd_idx,
    input  logic              upd_taken,
    input  logic              hist_restore,
    input  logic [HIST_W-1:0] hist_restore_val
);
    logic [HIST_W-1:0] hist;
    ctr_e              lookup_ctr;

    gshare_history #(.HIST_W(HIST_W)) u_hist (
        .clk         (clk),
        .rst         (rst),
        .shift_en    (upd_valid),
        .shift_bit   (upd_taken),
        .restore_en  (hist_restore),
        .restore_val (hist_restore_val),
        .hist        (hist)
    );

    gshare_hash #(.HIST_W(HIST_W), .PC_W(PC_W), .PC_LSB(PC_LSB)) u_hash (
        .pc   (pred_pc),
        .hist (hist),
        .idx  (pred_idx)
    );

    gshare_pht #(.IDX_W(HIST_W)) u_pht (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (pred_idx),
        .rd_ctr   (lookup_ctr),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken)
    );

    assign pred_taken = ctr_says_taken(lookup_ctr);
endmodule

// File: rtl/gshare_predictor_chk.sv
module gshare_predictor_chk #(
    parameter int HIST_W = 10,
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [PC_W-1:0]   pred_pc,
    input logic              pred_taken,
    input logic [HIST_W-1:0] pred_idx,
    input logic              upd_valid,
    input logic              upd_taken,
    input logic              hist_restore,
    input logic [HIST_W-1:0] hist_restore_val
);
    logic [HIST_W-1:0] hist_seen;
    logic [HIST_W-1:0] hist_shifted;

    assign hist_seen    = pred_idx ^ pred_pc[PC_LSB +: HIST_W];
    assign hist_shifted = {hist_seen[HIST_W-2:0], upd_taken};

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (hist_seen == '0) && pred_taken);

    // R7
    a_r7_shift_in: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !hist_restore) |=> hist_seen == $past(hist_shifted));

    // R8
    a_r8_restore_wins: assert property (@(posedge clk) disable iff (rst)
        hist_restore |=> hist_seen == $past(hist_restore_val));

    // R9
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!upd_valid && !hist_restore) |=> hist_seen == $past(hist_seen));
endmodule

bind gshare_predictor gshare_predictor_chk #(
    .HIST_W (HIST_W),
    .PC_W   (PC_W),
    .PC_LSB (PC_LSB)
) u_chk (
    .clk              (clk),
    .rst              (rst),
    .pred_pc          (pred_pc),
    .pred_taken       (pred_taken),
    .pred_idx         (pred_idx),
    .upd_valid        (upd_valid),
    .upd_taken        (upd_taken),
    .hist_restore     (hist_restore),
    .hist_restore_val (hist_restore_val)
);

// File: tb/gshare_predictor_bench.sv
module gshare_predictor_bench;
    localparam int HW    = 4;
    localparam int PW    = 16;
    localparam int LSB   = 2;
    localparam int DEPTH = 1 << HW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PW-1:0] pred_pc = '0;
    logic          pred_taken;
    logic [HW-1:0] pred_idx;
    logic          upd_valid = 1'b0;
    logic [HW-1:0] upd_idx = '0;
    logic          upd_taken = 1'b0;
    logic          hist_restore = 1'b0;
    logic [HW-1:0] hist_restore_val = '0;

    int n_checks = 0;
    int n_fail   = 0;

    logic [HW-1:0] m_hist;
    logic [1:0]    m_ctr [DEPTH];

    always #5 clk = ~clk;

    gshare_predictor #(.HIST_W(HW), .PC_W(PW), .PC_LSB(LSB)) u_gshare_predictor (
        .clk (clk), .rst (rst), .pred_pc (pred_pc), .pred_taken (pred_taken),
        .pred_idx (pred_idx), .upd_valid (upd_valid), .upd_idx (upd_idx),
        .upd_taken (upd_taken), .hist_restore (hist_restore),
        .hist_restore_val (hist_restore_val)
    );

    function automatic logic [1:0] m_step(input logic [1:0] c, input logic t);
        if (t) return (c == 2'b11) ? c : c + 2'b01;
        return (c == 2'b00) ? c : c - 2'b01;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] pc_for(input logic [HW-1:0] idx);
        logic [PW-1:0] p = '0;
        p[LSB +: HW] = m_hist ^ idx;
        return p;
    endfunction

    // Look up counter idx through the port and compare with the model.
    task automatic probe(input logic [HW-1:0] idx, input string req);
        pred_pc = pc_for(idx);
        #1;
        check(pred_idx == idx, req, int'(pred_idx), int'(idx));
        check(pred_taken == m_ctr[idx][1], req, int'(pred_taken), int'(m_ctr[idx][1]));
    endtask

    task automatic scan(input string req);
        for (int i = 0; i < DEPTH; i++) probe(HW'(i), req);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_hist = '0;
        for (int i = 0; i < DEPTH; i++) m_ctr[i] = 2'b10;
    endtask

    // One edge with the given controls; model follows.
    task automatic edge_op(input bit v, input logic [HW-1:0] idx, input bit t,
                           input bit rs, input logic [HW-1:0] rv);
        upd_valid = v; upd_idx = idx; upd_taken = t;
        hist_restore = rs; hist_restore_val = rv;
        @(negedge clk);
        upd_valid = 1'b0; hist_restore = 1'b0;
        if (v) m_ctr[idx] = m_step(m_ctr[idx], t);
        if (rs) m_hist = rv;
        else if (v) m_hist = {m_hist[HW-2:0], t};
    endtask

    task automatic t_reset();
        do_reset();
        for (int i = 0; i < DEPTH; i++) begin
            pred_pc = PW'(i << LSB) | PW'(16'hA001 & 16'hF003);
            #1;
            check(pred_idx == HW'(i), "R2 index after reset", int'(pred_idx), i);
            check(pred_taken == 1'b1, "R1 weakly taken after reset", int'(pred_taken), 1);
        end
    endtask

    task automatic t_saturate();
        logic [HW-1:0] k = 4'd3;
        do_reset();
        edge_op(1, k, 1, 0, '0); probe(k, "R4 up to strong taken");
        edge_op(1, k, 1, 0, '0); probe(k, "R4 saturate at 11");
        edge_op(1, k, 1, 0, '0); probe(k, "R4 saturate at 11");
        edge_op(1, k, 0, 0, '0); probe(k, "R5 one miss keeps taken");
        edge_op(1, k, 0, 0, '0); probe(k, "R5 second miss flips to not taken");
        check(pred_taken == 1'b0, "R3 counter 01 predicts not taken", int'(pred_taken), 0);
        edge_op(1, k, 0, 0, '0); probe(k, "R4 down to 00");
        edge_op(1, k, 0, 0, '0); probe(k, "R4 saturate at 00");
        edge_op(1, k, 1, 0, '0); probe(k, "R5 one hit keeps not taken");
        check(pred_taken == 1'b0, "R5 strong not taken holds", int'(pred_taken), 0);
        scan("R6 only counter 3 trained");
    endtask

    task automatic t_history();
        do_reset();
        edge_op(1, 4'd0, 1, 0, '0);
        edge_op(1, 4'd1, 1, 0, '0);
        edge_op(1, 4'd2, 1, 0, '0);
        edge_op(1, 4'd3, 0, 0, '0);
        pred_pc = '0; #1;
        check(pred_idx == 4'b1110, "R7 history TTTN", int'(pred_idx), 14);
        edge_op(1, 4'd4, 1, 0, '0);
        pred_pc = '0; #1;
        check(pred_idx == 4'b1101, "R7 history TTNT", int'(pred_idx), 13);
        scan("R7 table after shifts");
    endtask

    task automatic t_restore();
        do_reset();
        edge_op(1, 4'd7, 0, 0, '0);
        edge_op(1, 4'd5, 0, 1, 4'b1010);
        pred_pc = '0; #1;
        check(pred_idx == 4'b1010, "R8 restore overrides shift", int'(pred_idx), 10);
        probe(4'd5, "R8 counter still trained on restore");
        check(pred_taken == 1'b0, "R8 counter 5 now weak not taken", int'(pred_taken), 0);
        edge_op(0, 4'd0, 0, 1, 4'b0110);
        pred_pc = '0; #1;
        check(pred_idx == 4'b0110, "R8 restore alone", int'(pred_idx), 6);
        scan("R8 table after restore");
    endtask

    task automatic t_idle();
        logic [HW-1:0] h0;
        do_reset();
        edge_op(1, 4'd9, 0, 0, '0);
        edge_op(1, 4'd9, 0, 0, '0);
        h0 = m_hist;
        upd_idx = 4'd9; upd_taken = 1'b1;
        hist_restore_val = 4'hF;
        repeat (5) @(negedge clk);
        pred_pc = '0; #1;
        check(pred_idx == h0, "R9 history held while idle", int'(pred_idx), int'(h0));
        scan("R9 counters held while idle");
    endtask

    task automatic t_supplied_idx();
        logic [HW-1:0] lk;
        do_reset();
        pred_pc = PW'(16'h0024);
        #1;
        lk = pred_idx;
        edge_op(0, '0, 0, 1, 4'b0101);
        edge_op(1, lk, 0, 0, '0);
        edge_op(1, lk, 0, 0, '0);
        probe(lk, "R6 supplied index trained");
        check(pred_taken == 1'b0, "R6 looked-up counter moved", int'(pred_taken), 0);
        scan("R6 no other counter touched");
    endtask

    task automatic t_alternate();
        logic [HW-1:0] k = 4'd9;
        int right = 0;
        bit outc;
        do_reset();
        for (int i = 0; i < 20; i++) begin
            outc = (i % 2) == 0;
            pred_pc = pc_for(k);
            #1;
            check(pred_idx == k, "R10 steered to one counter", int'(pred_idx), int'(k));
            if (pred_taken == outc) right++;
            edge_op(1, k, outc, 0, '0);
        end
        check(right == 10, "R10 alternating accuracy 50%", right, 10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_saturate();
        t_history();
        t_restore();
        t_idle();
        t_supplied_idx();
        t_alternate();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #500000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule